// File: doc/BRIEF.md
# Packet Queue Host Access Port

This block lets a host processor reach a set of packet queues through a handful of fixed register addresses. Two receive queues are filled by the link-side receiver. The host drains each one through a single address, and that read is destructive. One transmit queue is filled by the host and drained by the link-side transmitter. Every entry is a 32-bit quadlet that carries an end-of-packet tag.

A host read of a receive-queue address moves the oldest quadlet of that queue into a read shadow register. The quadlet then leaves the queue, and all further host access to that data goes through the shadow. The transmit queue has two write addresses. A write to the body address stores an untagged quadlet. A write to the final address stores a tagged quadlet and so marks a whole packet as ready to send. The block raises a packet-ready output for as long as at least one complete packet is queued.

Host status flags show when a receive queue has data and when the transmit queue has room. Each flag drops for one cycle after every push or pop on its queue, which models the access latency. A pop from an empty queue or a push into a full queue is ignored and sets a sticky error flag.

Top module: `pq_host_port`

## Requirements
- R1: After reset the shadow holds data 0 with tag 0. No receive flag is high, the transmit space flag is high, packet-ready is low, both link ready outputs are high, tx_valid is low and every error flag is low.
- R2: A host read (host_sel=1, host_wr=0) of address i (0 or 1) while receive queue i is non-empty moves its oldest quadlet into host_shadow at the next clock edge. That quadlet is removed from the queue, so quadlets leave in arrival order.
- R3: The shadow changes only on an accepted receive pop. Host reads of address 2 or 3 and host writes to any address leave it unchanged. Host writes to address 0 or 1 change no queue.
- R4: A host write to address 2 stores host_wdata with tag 0. A write to address 3 stores it with tag 1. The consumer sees the entries in write order on tx_data/tx_eop while tx_valid is high, and tx_pop removes the head.
- R5: tx_pkt_ready is high exactly while the transmit queue holds at least one tag-1 entry. The count of such entries rises on an accepted address-3 write and falls when the consumer pops a tag-1 head.
- R6: host_rx_avail[i] is high when receive queue i is non-empty and no push or pop was accepted on it in the previous cycle. host_tx_space is high when the transmit queue is not full and no push or pop was accepted on it in the previous cycle.
- R7: A host read of an empty receive queue i is ignored and leaves the shadow unchanged. It sets host_rx_err[i], which stays high until reset.
- R8: A host write to a full transmit queue, with no consumer pop in the same cycle, is ignored. It sets host_tx_err, which stays high until reset.
- R9: A link push into receive queue i stores lnk_rx_data[i] with tag lnk_rx_eop[i]. lnk_rx_ready[i] is high when the queue is not full. A push into a full queue with no host pop in the same cycle is dropped.
- R10: host_shadow_eop gives the tag of the quadlet last moved into the shadow.
- R11: A push and a pop on the same queue in the same cycle both take effect, including when the queue is full. For the transmit queue, a tag-1 write together with a tag-1 pop leaves packet-ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0/1 receive queues, 2 transmit body, 3 transmit final |
| host_wdata | input | 32 | Host write quadlet |
| host_shadow | output | 32 | Read shadow data |
| host_shadow_eop | output | 1 | Tag of the quadlet in the shadow |
| host_rx_avail | output | 2 | Receive data available per queue |
| host_tx_space | output | 1 | Transmit slot free |
| host_rx_err | output | 2 | Sticky empty-read error per receive queue |
| host_tx_err | output | 1 | Sticky full-write error |
| lnk_rx_push | input | 2 | Link push per receive queue |
| lnk_rx_data | input | 64 | Link quadlet per receive queue (packed 2 x 32) |
| lnk_rx_eop | input | 2 | Link end-of-packet tag per receive queue |
| lnk_rx_ready | output | 2 | Receive queue not full |
| tx_pop | input | 1 | Consumer pop of transmit head |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_data | output | 32 | Transmit head quadlet |
| tx_eop | output | 1 | Transmit head tag |
| tx_pkt_ready | output | 1 | At least one complete packet queued |

## Verification
The delicate case is a push and a pop landing on one queue in the same cycle. On a receive queue, this is a link push during a host read. On the transmit queue, it is a host write during a consumer pop. It matters most when the queue is full, and when both transmit entries carry the end-of-packet tag. The bench sets up a full receive queue and a one-packet transmit queue and then fires both operations on one edge. A behavioural queue model judges the result each cycle through occupancy, drain order, ready flags and packet-ready. A long random phase with a high operation rate then repeats these collisions many more times.

// File: rtl/pq_pkg.sv
package pq_pkg;
  parameter int unsigned QW = 32;

  typedef struct packed {
    logic          eop;
    logic [QW-1:0] data;
  } entry_t;
endpackage

// File: rtl/pq_fifo.sv
module pq_fifo
  import pq_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push_i,
  input  logic   pop_i,
  input  entry_t din_i,
  output entry_t head_o,
  output logic   empty_o,
  output logic   full_o,
  output logic   push_acc_o,
  output logic   pop_acc_o,
  output logic   busy_o
);

  entry_t        mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          busy_q, busy_d;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o    = (lvl_q == '0);
  assign full_o     = (lvl_q == CW'(DEPTH));
  assign pop_acc_o  = pop_i && !empty_o;
  assign push_acc_o = push_i && (!full_o || pop_acc_o);
  assign head_o     = mem[rd_q];
  assign busy_o     = busy_q;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    lvl_d  = lvl_q;
    busy_d = push_acc_o || pop_acc_o;
    if (push_acc_o) wr_d = step_ptr(wr_q);
    if (pop_acc_o)  rd_d = step_ptr(rd_q);
    case ({push_acc_o, pop_acc_o})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      lvl_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      lvl_q  <= lvl_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc_o) mem[wr_q] <= din_i;
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH));

  // R11
  dual_op_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc_o && pop_acc_o) |=> $stable(lvl_q));

endmodule

// File: rtl/pq_pkt_count.sv
module pq_pkt_count #(
  parameter int unsigned CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic ready_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({inc_i, dec_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q != '0);

  // R5
  tag_pop_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0));

endmodule

// File: rtl/pq_host_port.sv
module pq_host_port
  import pq_pkg::*;
#(
  parameter  int unsigned NUM_RX = 2,
  parameter  int unsigned DEPTH  = 4,
  localparam int unsigned AW     = $clog2(NUM_RX + 2),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_sel,
  input  logic                      host_wr,
  input  logic [AW-1:0]             host_addr,
  input  logic [QW-1:0]             host_wdata,
  output logic [QW-1:0]             host_shadow,
  output logic                      host_shadow_eop,
  output logic [NUM_RX-1:0]         host_rx_avail,
  output logic                      host_tx_space,
  output logic [NUM_RX-1:0]         host_rx_err,
  output logic                      host_tx_err,
  input  logic [NUM_RX-1:0]         lnk_rx_push,
  input  logic [NUM_RX-1:0][QW-1:0] lnk_rx_data,
  input  logic [NUM_RX-1:0]         lnk_rx_eop,
  output logic [NUM_RX-1:0]         lnk_rx_ready,
  input  logic                      tx_pop,
  output logic                      tx_valid,
  output logic [QW-1:0]             tx_data,
  output logic                      tx_eop,
  output logic                      tx_pkt_ready
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // address decode
  logic [NUM_RX-1:0] rd_rx;
  logic              tx_wr, tx_last;

  assign tx_wr   = host_sel && host_wr &&
                   ((host_addr == AW'(NUM_RX)) || (host_addr == AW'(NUM_RX + 1)));
  assign tx_last = (host_addr == AW'(NUM_RX + 1));

  // receive queues
  entry_t            rx_head [NUM_RX];
  logic [NUM_RX-1:0] rx_empty, rx_full, rx_push_acc, rx_pop_acc, rx_busy;

  for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
    entry_t lnk_entry;
    assign rd_rx[i]   = host_sel && !host_wr && (host_addr == AW'(i));
    assign lnk_entry  = '{eop: lnk_rx_eop[i], data: lnk_rx_data[i]};

    pq_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
      .clk        (clk),
      .rst_n      (rst_i),
      .push_i     (lnk_rx_push[i]),
      .pop_i      (rd_rx[i]),
      .din_i      (lnk_entry),
      .head_o     (rx_head[i]),
      .empty_o    (rx_empty[i]),
      .full_o     (rx_full[i]),
      .push_acc_o (rx_push_acc[i]),
      .pop_acc_o  (rx_pop_acc[i]),
      .busy_o     (rx_busy[i])
    );

    assign host_rx_avail[i] = !rx_empty[i] && !rx_busy[i];
    assign lnk_rx_ready[i]  = !rx_full[i];

    // R6
    rx_flag_after_op_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (rx_push_acc[i] || rx_pop_acc[i]) |=> !host_rx_avail[i]);

    // R7
    empty_read_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (rd_rx[i] && rx_empty[i]) |=> (host_rx_err[i] && $stable(host_shadow)));

    // R7
    rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
      host_rx_err[i] |=> host_rx_err[i]);
  end

  // read shadow
  entry_t shadow_q, shadow_d;
  logic   shadow_en;

  assign shadow_en = |rx_pop_acc;

  always_comb begin
    shadow_d = shadow_q;
    for (int i = 0; i < NUM_RX; i++) begin
      if (rx_pop_acc[i]) shadow_d = rx_head[i];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  assign host_shadow     = shadow_q.data;
  assign host_shadow_eop = shadow_q.eop;

  // transmit queue
  entry_t tx_entry, tx_head;
  logic   tx_empty, tx_full, tx_push_acc, tx_pop_acc, tx_busy;

  assign tx_entry = '{eop: tx_last, data: host_wdata};

  pq_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk        (clk),
    .rst_n      (rst_i),
    .push_i     (tx_wr),
    .pop_i      (tx_pop),
    .din_i      (tx_entry),
    .head_o     (tx_head),
    .empty_o    (tx_empty),
    .full_o     (tx_full),
    .push_acc_o (tx_push_acc),
    .pop_acc_o  (tx_pop_acc),
    .busy_o     (tx_busy)
  );

  pq_pkt_count #(.CW(CW)) u_pkt_count (
    .clk     (clk),
    .rst_n   (rst_i),
    .inc_i   (tx_push_acc && tx_last),
    .dec_i   (tx_pop_acc && tx_head.eop),
    .ready_o (tx_pkt_ready)
  );

  assign tx_valid      = !tx_empty;
  assign tx_data       = tx_head.data;
  assign tx_eop        = tx_head.eop;
  assign host_tx_space = !tx_full && !tx_busy;

  // sticky errors
  logic [NUM_RX-1:0] rx_err_q, rx_err_d;
  logic              tx_err_q, tx_err_d;

  always_comb begin
    rx_err_d = rx_err_q | (rd_rx & rx_empty);
    tx_err_d = tx_err_q | (tx_wr && !tx_push_acc);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rx_err_q <= '0;
      tx_err_q <= 1'b0;
    end else begin
      rx_err_q <= rx_err_d;
      tx_err_q <= tx_err_d;
    end
  end

  assign host_rx_err = rx_err_q;
  assign host_tx_err = tx_err_q;

  // R3
  write_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (host_sel && host_wr) |=> $stable(host_shadow));

  // R6
  tx_flag_after_op_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_push_acc || tx_pop_acc) |=> !host_tx_space);

  // R8
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_wr && tx_full && !tx_pop) |=> (host_tx_err && tx_full));

  // R4
  tx_valid_after_push_chk: assert property (@(posedge clk) disable iff (!rst_i)
    tx_push_acc |=> tx_valid);

endmodule

// File: tb/pq_host_port_bench.sv
module pq_host_port_bench;
  localparam int DEPTH = 4;
  localparam int WATCHDOG_CYC = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             host_sel, host_wr;
  logic [1:0]       host_addr;
  logic [31:0]      host_wdata;
  logic [31:0]      host_shadow;
  logic             host_shadow_eop;
  logic [1:0]       host_rx_avail, host_rx_err, lnk_rx_push, lnk_rx_eop, lnk_rx_ready;
  logic             host_tx_space, host_tx_err;
  logic [1:0][31:0] lnk_rx_data;
  logic             tx_pop, tx_valid, tx_eop, tx_pkt_ready;
  logic [31:0]      tx_data;

  always #2 clk = ~clk;

  pq_host_port #(.NUM_RX(2), .DEPTH(DEPTH)) u_pq_host_port (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_shadow(host_shadow), .host_shadow_eop(host_shadow_eop),
    .host_rx_avail(host_rx_avail), .host_tx_space(host_tx_space),
    .host_rx_err(host_rx_err), .host_tx_err(host_tx_err),
    .lnk_rx_push(lnk_rx_push), .lnk_rx_data(lnk_rx_data), .lnk_rx_eop(lnk_rx_eop),
    .lnk_rx_ready(lnk_rx_ready),
    .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_data(tx_data), .tx_eop(tx_eop),
    .tx_pkt_ready(tx_pkt_ready)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [32:0] q0[$], q1[$], qt[$];
  logic [32:0] m_sh;
  bit          mb0, mb1, mbt, me0, me1, met, m_on;
  int          m_pk;

  always @(posedge clk) begin
    if (m_on) begin
      bit rd, pop_ok, push_ok, twr;
      rd = host_sel && !host_wr && host_addr == 2'd0;
      pop_ok = rd && q0.size() > 0;
      if (rd && q0.size() == 0) me0 = 1;
      push_ok = lnk_rx_push[0] && (q0.size() < DEPTH || pop_ok);
      if (pop_ok) m_sh = q0.pop_front();
      if (push_ok) q0.push_back({lnk_rx_eop[0], lnk_rx_data[0]});
      mb0 = pop_ok || push_ok;

      rd = host_sel && !host_wr && host_addr == 2'd1;
      pop_ok = rd && q1.size() > 0;
      if (rd && q1.size() == 0) me1 = 1;
      push_ok = lnk_rx_push[1] && (q1.size() < DEPTH || pop_ok);
      if (pop_ok) m_sh = q1.pop_front();
      if (push_ok) q1.push_back({lnk_rx_eop[1], lnk_rx_data[1]});
      mb1 = pop_ok || push_ok;

      twr = host_sel && host_wr && host_addr[1];
      pop_ok = tx_pop && qt.size() > 0;
      push_ok = twr && (qt.size() < DEPTH || pop_ok);
      if (twr && !push_ok) met = 1;
      if (pop_ok) begin
        if (qt[0][32]) m_pk--;
        void'(qt.pop_front());
      end
      if (push_ok) begin
        qt.push_back({host_addr[0], host_wdata});
        if (host_addr[0]) m_pk++;
      end
      mbt = pop_ok || push_ok;
    end
  end

  always @(negedge clk) begin
    if (m_on && !done) begin
      chk(host_shadow == m_sh[31:0], "R2 shadow", host_shadow, m_sh[31:0]);
      chk(host_shadow_eop == m_sh[32], "R10 shadow tag", host_shadow_eop, m_sh[32]);
      chk(host_rx_avail[0] == (q0.size() > 0 && !mb0), "R6 rx0 avail", host_rx_avail[0], (q0.size() > 0 && !mb0));
      chk(host_rx_avail[1] == (q1.size() > 0 && !mb1), "R6 rx1 avail", host_rx_avail[1], (q1.size() > 0 && !mb1));
      chk(host_tx_space == (qt.size() < DEPTH && !mbt), "R6 tx space", host_tx_space, (qt.size() < DEPTH && !mbt));
      chk(lnk_rx_ready == {q1.size() < DEPTH, q0.size() < DEPTH}, "R9 rx ready", lnk_rx_ready, {q1.size() < DEPTH, q0.size() < DEPTH});
      chk(tx_valid == (qt.size() > 0), "R4 tx valid", tx_valid, qt.size() > 0);
      if (qt.size() > 0)
        chk({tx_eop, tx_data} == qt[0], "R4 tx head", {tx_eop, tx_data}, qt[0]);
      chk(tx_pkt_ready == (m_pk > 0), "R5 pkt ready", tx_pkt_ready, m_pk > 0);
      chk(host_rx_err == {me1, me0}, "R7 rx err", host_rx_err, {me1, me0});
      chk(host_tx_err == met, "R8 tx err", host_tx_err, met);
    end
  end

  task automatic idle();
    host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    lnk_rx_push = 0; lnk_rx_eop = 0; lnk_rx_data = '0; tx_pop = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic hread(input logic [1:0] a);
    host_sel = 1; host_wr = 0; host_addr = a;
    tick();
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    tick();
  endtask

  task automatic lpush(input int q, input logic [31:0] d, input bit e);
    lnk_rx_push[q] = 1; lnk_rx_data[q] = d; lnk_rx_eop[q] = e;
    tick();
  endtask

  initial begin
    #(WATCHDOG_CYC * 4);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    m_on = 0; m_sh = '0; mb0 = 0; mb1 = 0; mbt = 0; me0 = 0; me1 = 0; met = 0; m_pk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(host_shadow == 0 && host_shadow_eop == 0, "R1 shadow", {host_shadow_eop, host_shadow}, 0);
    chk(host_rx_avail == 0 && host_tx_space == 1, "R1 flags", {host_rx_avail, host_tx_space}, 3'b001);
    chk(tx_pkt_ready == 0 && tx_valid == 0, "R1 tx", {tx_pkt_ready, tx_valid}, 0);
    chk(lnk_rx_ready == 2'b11 && host_rx_err == 0 && host_tx_err == 0, "R1 ready/err",
        {lnk_rx_ready, host_rx_err, host_tx_err}, 5'b11000);
    m_on = 1;

    // R7: empty read
    hread(2'd0);
    tick();
    chk(host_rx_err == 2'b01, "R7 empty read err", host_rx_err, 2'b01);
    chk(host_shadow == 0, "R7 shadow kept", host_shadow, 0);

    // R9: fill rx0, extra push dropped
    for (int k = 0; k < DEPTH; k++) lpush(0, 32'hA000_0000 + k, k == DEPTH - 1);
    lpush(0, 32'hDEAD_0001, 0);
    chk(lnk_rx_ready[0] == 0, "R9 full", lnk_rx_ready[0], 0);

    // R11: pop and push together on full rx0
    host_sel = 1; host_addr = 2'd0;
    lnk_rx_push[0] = 1; lnk_rx_data[0] = 32'hB000_0001; lnk_rx_eop[0] = 1;
    tick();
    chk(host_shadow == 32'hA000_0000, "R2 first pop", host_shadow, 32'hA000_0000);
    chk(lnk_rx_ready[0] == 0, "R11 rx still full", lnk_rx_ready[0], 0);
    chk(host_rx_avail[0] == 0, "R6 flag low after op", host_rx_avail[0], 0);
    tick();
    chk(host_rx_avail[0] == 1, "R6 flag back", host_rx_avail[0], 1);

    // R3: writes to rx addresses and reads of tx addresses ignored
    hwrite(2'd0, 32'h1111_2222);
    hread(2'd2);
    hread(2'd3);
    chk(host_shadow == 32'hA000_0000, "R3 shadow unchanged", host_shadow, 32'hA000_0000);

    // drain rx0, fill and drain rx1
    for (int k = 0; k < DEPTH; k++) begin hread(2'd0); tick(); end
    chk(host_shadow == 32'hB000_0001 && host_shadow_eop == 1, "R10 last tag",
        {host_shadow_eop, host_shadow}, {1'b1, 32'hB000_0001});
    for (int k = 0; k < 3; k++) lpush(1, 32'hC000_0000 + k, k == 2);
    for (int k = 0; k < 3; k++) hread(2'd1);

    // R4/R5: one packet through tx
    hwrite(2'd2, 32'hD000_0000);
    hwrite(2'd2, 32'hD000_0001);
    chk(tx_pkt_ready == 0, "R5 no packet yet", tx_pkt_ready, 0);
    hwrite(2'd3, 32'hD000_0002);
    chk(tx_pkt_ready == 1, "R5 packet ready", tx_pkt_ready, 1);
    repeat (3) begin tx_pop = 1; tick(); end
    chk(tx_pkt_ready == 0 && tx_valid == 0, "R5 drained", {tx_pkt_ready, tx_valid}, 0);

    // R8: overfill tx
    for (int k = 0; k < DEPTH; k++) hwrite(k == DEPTH - 1 ? 2'd3 : 2'd2, 32'hE000_0000 + k);
    hwrite(2'd2, 32'hEEEE_EEEE);
    chk(host_tx_err == 1, "R8 overrun err", host_tx_err, 1);
    repeat (DEPTH) begin tx_pop = 1; tick(); end

    // R11: tagged write and tagged pop together
    hwrite(2'd3, 32'hF000_0000);
    host_sel = 1; host_wr = 1; host_addr = 2'd3; host_wdata = 32'hF000_0001; tx_pop = 1;
    tick();
    chk(tx_pkt_ready == 1, "R11 pkt ready kept", tx_pkt_ready, 1);
    chk(tx_data == 32'hF000_0001 && tx_eop == 1, "R11 tx head", {tx_eop, tx_data}, {1'b1, 32'hF000_0001});

    // random phase
    for (int n = 0; n < 4000; n++) begin
      host_sel = ($urandom % 2) == 0;
      host_wr = $urandom % 2;
      host_addr = 2'($urandom % 4);
      host_wdata = $urandom;
      lnk_rx_push = 2'($urandom % 4);
      lnk_rx_eop = 2'($urandom % 4);
      lnk_rx_data[0] = $urandom;
      lnk_rx_data[1] = $urandom;
      tx_pop = ($urandom % 3) == 0;
      tick();
    end

    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule